// File: doc/BRIEF.md
# Clock Source-Select, Divide and Gate Cell

This cell turns a set of input clocks into one output clock. A source stage picks either a dedicated bypass clock or one clock from a bank of up to eight. The picked clock drives a programmable divider and a fixed divide-by-three. An output selector picks one of those two results, and an enable gate follows the selector. All controls are static fields supplied by a register block outside the cell.

Changes to the divider controls are held back until the divider counter wraps. The enable is synchronised and is applied only while the output is low. Because of this, reprogramming the cell never produces a short pulse on the output. Two parameters remove the source stage or the gate stage. Without the source stage the cell always runs from the bypass clock. Without the gate stage the output runs all the time.

Top module: `clk_sdg_cell`

## Requirements
- R1: With `src_sw`=0 the divider runs from `clk_byp`. With `src_sw`=1 it runs from `clk_bank[bank_sel]`. Parent index 0 therefore means the bypass clock, and index k>0 means bank clock k-1.
- R2: With `div_sw`=1 and `d3_sw`=0, the codes 0, 1, 2, 3, 4 and 5 of `div_sel` divide the source by 1, 2, 4, 6, 8 and 12.
- R3: With `div_sw`=1 and `d3_sw`=0, the codes 6 and 7 of `div_sel` divide by 1.
- R4: With `div_sw`=0 and `d3_sw`=0 the output period equals the source period, whatever `div_sel` holds.
- R5: With `d3_sw`=1 the output period is three source periods, whatever `div_sw` and `div_sel` hold.
- R6: Even ratios give a high time of exactly half the output period. Ratio 3 gives a high time of one source period.
- R7: A new ratio takes effect only when the divider counter wraps. While the ratio changes, no high or low phase of the output is shorter than half a source period.
- R8: The output follows `en`, which is synchronised to the source. `en`=0 holds the output low. Toggling `en` never shortens a high phase of the output.
- R9: While `rst_n` is low the output is low. The counters restart from zero after reset is released.
- R10: With `HAS_MUX`=0 the cell uses `clk_byp` whatever `src_sw` holds. With `HAS_GATE`=0 the output runs even when `en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_byp | input | 1 | Dedicated bypass source clock |
| clk_bank | input | NBANK | Bank of selectable source clocks |
| src_sw | input | 1 | 0: bypass clock, 1: bank clock |
| bank_sel | input | SELW | Bank clock index |
| div_sw | input | 1 | 0: programmable divider bypassed |
| div_sel | input | 3 | Programmable ratio code |
| d3_sw | input | 1 | 1: fixed divide-by-three output |
| en | input | 1 | Output clock enable |
| clk_o | output | 1 | Gated output clock |

## Verification
The hardest conditions to reach from the ports are a ratio change and an enable change that land in the middle of an output high phase. The stimulus covers both. It toggles `div_sel` between a long ratio and a short one at times unrelated to the output phase. It also toggles `en` every 17 ns while the output runs at ratio 8. Throughout both, a monitor records the shortest high phase and the shortest low phase seen on the output. The bank clocks all have different periods, so each measured output period identifies both the source that was picked and the ratio applied to it.

// File: rtl/clk_sdg_cell.sv
module clk_sdg_cell #(
  parameter int NBANK    = 8,
  parameter int SELW     = 3,
  parameter int CNTW     = 4,
  parameter bit HAS_MUX  = 1'b1,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic             rst_n,
  input  logic             clk_byp,
  input  logic [NBANK-1:0] clk_bank,
  input  logic             src_sw,
  input  logic [SELW-1:0]  bank_sel,
  input  logic             div_sw,
  input  logic [2:0]       div_sel,
  input  logic             d3_sw,
  input  logic             en,
  output logic             clk_o
);

  localparam logic [CNTW-1:0] ONE = CNTW'(1);

  logic            src_clk;
  logic [CNTW-1:0] cnt, cur, nxt, tbl;
  logic            div_q, pre;

  if (HAS_MUX) begin : g_mux
    assign src_clk = src_sw ? clk_bank[bank_sel] : clk_byp;
  end else begin : g_nomux
    assign src_clk = clk_byp;
  end

  always_comb begin
    case (div_sel)
      3'd1:    tbl = CNTW'(2);
      3'd2:    tbl = CNTW'(4);
      3'd3:    tbl = CNTW'(6);
      3'd4:    tbl = CNTW'(8);
      3'd5:    tbl = CNTW'(12);
      default: tbl = ONE;
    endcase
  end

  assign nxt = d3_sw ? CNTW'(3) : (div_sw ? tbl : ONE);

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cur   <= ONE;
      div_q <= 1'b0;
    end else if (cnt >= cur - ONE) begin
      cnt   <= '0;
      cur   <= nxt;
      div_q <= (nxt > ONE);
    end else begin
      cnt   <= cnt + ONE;
      div_q <= (cnt + ONE) < (cur >> 1);
    end
  end

  assign pre = (cur == ONE) ? src_clk : div_q;

  if (HAS_GATE) begin : g_gate
    logic en_s1, en_s2, en_g;
    always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
        en_s1 <= 1'b0;
        en_s2 <= 1'b0;
        en_g  <= 1'b0;
      end else begin
        en_s1 <= en;
        en_s2 <= en_s1;
        if (cur == ONE || !div_q) en_g <= en_s2;
      end
    end
    assign clk_o = pre & en_g;
  end else begin : g_nogate
    assign clk_o = pre;
  end

  assert_ratio_holds_R7: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cnt < cur - ONE) |=> $stable(cur));
  assert_cnt_in_range_R7: assert property (@(posedge src_clk) disable iff (!rst_n)
    cnt < cur);
  assert_div3_wins_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cnt >= cur - ONE && d3_sw) |=> cur == CNTW'(3));
  assert_bypass_one_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cnt >= cur - ONE && !d3_sw && !div_sw) |=> cur == ONE);
  assert_top_code_R2: assert property (@(posedge src_clk) disable iff (!rst_n)
    (cnt >= cur - ONE && !d3_sw && div_sw && div_sel == 3'd5) |=> cur == CNTW'(12));

endmodule

// File: tb/clk_sdg_cell_test.sv
`timescale 1ns/1ps
module clk_sdg_cell_test;
  localparam int BYP_PER = 10;

  logic       rst_n = 1'b0, clk_byp = 1'b0;
  logic [7:0] clk_bank = '0;
  logic       src_sw = 1'b0, div_sw = 1'b0, d3_sw = 1'b0, en = 1'b0;
  logic [2:0] bank_sel = '0, div_sel = '0;
  logic       clk_o, clk_bare;
  int tests = 0, fails = 0;

  clk_sdg_cell uut (.rst_n, .clk_byp, .clk_bank, .src_sw, .bank_sel, .div_sw,
                    .div_sel, .d3_sw, .en, .clk_o(clk_o));
  clk_sdg_cell #(.HAS_MUX(1'b0), .HAS_GATE(1'b0)) uut_bare (.rst_n, .clk_byp,
    .clk_bank, .src_sw, .bank_sel, .div_sw, .div_sel, .d3_sw, .en, .clk_o(clk_bare));

  always #(BYP_PER/2) clk_byp = ~clk_byp;
  for (genvar k = 0; k < 8; k++) begin : g_src
    always #(6 + k) clk_bank[k] = ~clk_bank[k];
  end

  function automatic int ratio_of(bit d3, bit dsw, int code);
    if (d3) return 3;
    if (!dsw) return 1;
    case (code)
      1: return 2; 2: return 4; 3: return 6; 4: return 8; 5: return 12;
      default: return 1;
    endcase
  endfunction

  function automatic int high_of(int r, int sp);
    return (r == 1) ? sp / 2 : (r / 2) * sp;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(bit bare, output int per, output int hi);
    time t0, t1, t2;
    if (bare) @(posedge clk_bare); else @(posedge clk_o);
    t0 = $time;
    if (bare) @(negedge clk_bare); else @(negedge clk_o);
    t1 = $time;
    if (bare) @(posedge clk_bare); else @(posedge clk_o);
    t2 = $time;
    per = int'(t2 - t0);
    hi  = int'(t1 - t0);
  endtask

  bit  mon_on = 1'b0;
  int  min_hi = 1000000, min_lo = 1000000;
  time last_edge = 0;
  always @(clk_o) begin
    if (mon_on) begin
      if (!clk_o && int'($time - last_edge) < min_hi) min_hi = int'($time - last_edge);
      if (clk_o && int'($time - last_edge) < min_lo) min_lo = int'($time - last_edge);
    end
    last_edge = $time;
  end

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int per, hi, r, sp, ones;
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      #3; if (clk_o) ones++;
    end
    chk(ones == 0, "R9 reset output low", ones, 0);
    rst_n = 1'b1;
    en = 1'b1;
    #2000;
    measure(0, per, hi);
    chk(per == BYP_PER, "R1/R4 bypass period", per, BYP_PER);
    chk(hi == BYP_PER/2, "R4 bypass high", hi, BYP_PER/2);

    div_sw = 1'b0; div_sel = 3'd5; #2000;
    measure(0, per, hi);
    chk(per == BYP_PER, "R4 div_sw=0 ignores code", per, BYP_PER);

    div_sw = 1'b1;
    for (int c = 0; c < 8; c++) begin
      div_sel = 3'(c); #2000;
      r = ratio_of(0, 1, c);
      measure(0, per, hi);
      chk(per == r * BYP_PER, c < 6 ? "R2 ratio period" : "R3 ratio period", per, r * BYP_PER);
      chk(hi == high_of(r, BYP_PER), "R6 high time", hi, high_of(r, BYP_PER));
    end

    d3_sw = 1'b1; div_sel = 3'd5; #2000;
    measure(0, per, hi);
    chk(per == 3 * BYP_PER, "R5 div3 over code 5", per, 3 * BYP_PER);
    chk(hi == BYP_PER, "R6 div3 high third", hi, BYP_PER);
    div_sw = 1'b0; #2000;
    measure(0, per, hi);
    chk(per == 3 * BYP_PER, "R5 div3 over div_sw=0", per, 3 * BYP_PER);
    d3_sw = 1'b0; div_sw = 1'b1;

    src_sw = 1'b1; div_sel = 3'd1;
    for (int k = 0; k < 8; k++) begin
      bank_sel = 3'(k); #2000;
      sp = 2 * (6 + k);
      measure(0, per, hi);
      chk(per == 2 * sp, "R1 bank source period", per, 2 * sp);
    end

    src_sw = 1'b0; #2000;
    min_hi = 1000000; min_lo = 1000000; mon_on = 1'b1;
    for (int i = 0; i < 30; i++) begin
      div_sel = (i % 2 == 0) ? 3'd4 : 3'd1;
      #(53 + 7 * i);
    end
    mon_on = 1'b0;
    chk(min_hi >= BYP_PER/2, "R7 no runt high", min_hi, BYP_PER/2);
    chk(min_lo >= BYP_PER/2, "R7 no runt low", min_lo, BYP_PER/2);

    div_sel = 3'd4; #2000;
    min_hi = 1000000; mon_on = 1'b1;
    for (int i = 0; i < 120; i++) begin
      en = ~en; #17;
    end
    en = 1'b1; #400;
    mon_on = 1'b0;
    chk(min_hi >= 4 * BYP_PER, "R8 gate keeps high phase whole", min_hi, 4 * BYP_PER);

    en = 1'b0; #500;
    ones = 0;
    for (int i = 0; i < 100; i++) begin
      #3; if (clk_o) ones++;
    end
    chk(ones == 0, "R8 en=0 holds low", ones, 0);

    src_sw = 1'b1; bank_sel = 3'd3; div_sel = 3'd2; #2000;
    measure(1, per, hi);
    chk(per == 4 * BYP_PER, "R10 bare cell runs on bypass ungated", per, 4 * BYP_PER);

    rst_n = 1'b0; #7;
    ones = 0;
    for (int i = 0; i < 30; i++) begin
      #3; if (clk_o) ones++;
    end
    chk(ones == 0, "R9 reset mid-run output low", ones, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule